// File: doc/BRIEF.md
# Three-wire serial bus transaction monitor

This block watches a three-wire, half-duplex synchronous serial bus without driving it. It samples the four lines (select, serial clock, controller-to-peripheral data and peripheral-to-controller data) with a much faster system clock. For every select window it reports what happened. A window is either a bit transfer or a busy/ready status poll, and the block tells them apart by the data-in level at the first serial clock rising edge.

For a transfer, one record is produced per bit. The record carries the data-in value taken at the bit's rising edge, the data-out value taken at the following falling edge, and a flag on the leading start bit. The bit count of a transfer is not fixed, so the block closes each bit only when the next rising edge arrives, or at deselect. For a poll, the block buffers every level change on data-out while the window is open. After deselect it replays those changes, followed by the final level (low = busy, high = ready). Each window finishes with a done pulse that carries the number of bit records. A warning pulse flags a select that begins with the serial clock already high.

Top module: `mw_monitor`

## Requirements
- R1: While rst_ni is low and after its release with the bus idle, bit_valid_o, status_valid_o, warn_clk_high_o and txn_done_o all stay low.
- R2: Every select window (select rising then falling) yields exactly one txn_done_o pulse, after all of that window's records. txn_bits_o carries the number of bit records emitted, which is 0 for a poll.
- R3: If the serial clock is high when select rises, warn_clk_high_o pulses once. That high level is treated as low and its falling edge is ignored, so the first real rising edge still classifies the window and opens the start bit.
- R4: In a bit record, bit_si_o is the data-in level at that bit's rising edge and bit_so_o is the data-out level at the next falling edge.
- R5: If data-in is high at the first rising edge of a window, the window is a transfer and its first record has bit_is_start_o=1 and bit_si_o=1. Every later record has bit_is_start_o=0.
- R6: A bit record is emitted when the next rising edge arrives. The last bit is emitted at deselect if the serial clock is low. If the clock is still high at deselect, that last bit is not reported. Any number of bits is accepted.
- R7: A window with no rising edge, or with data-in low at its first rising edge, is a poll and produces no bit records, even if data-in is high at later rising edges.
- R8: After a poll window closes, status_valid_o pulses once per data-out level change seen during the window, in order, with status_ready_o equal to the new level (1 = ready, 0 = busy). One further pulse then gives the level at deselect. The records come on consecutive cycles and are followed by txn_done_o. Up to STAT_DEPTH changes are kept, and later changes are dropped.
- R9: Data-out changes inside a transfer window produce no status records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mw_cs_i | input | 1 | Bus select, active high |
| mw_sk_i | input | 1 | Bus serial clock |
| mw_si_i | input | 1 | Bus data toward the peripheral |
| mw_so_i | input | 1 | Bus data from the peripheral |
| bit_valid_o | output | 1 | One-cycle pulse: bit record valid |
| bit_si_o | output | 1 | Data-in value of the record |
| bit_so_o | output | 1 | Data-out value of the record |
| bit_is_start_o | output | 1 | Record is the start bit |
| status_valid_o | output | 1 | One-cycle pulse: status record valid |
| status_ready_o | output | 1 | 1 = ready, 0 = busy |
| warn_clk_high_o | output | 1 | Pulse: clock high at select |
| txn_done_o | output | 1 | Pulse: window finished |
| txn_bits_o | output | CNT_W | Bit records in the finished window |

## Verification
A bus edge passes through two synchronizer flops and one output register. A bit record therefore appears on the third system clock edge after the bus rising edge that closes it, and the last bit appears three edges after deselect. Status replay starts one cycle later (four edges after deselect) and runs one record per cycle, with txn_done_o one cycle after the last record. The bench samples the outputs on falling system clock edges and compares them by order against a reference queue. It leaves at least 30 idle cycles after every deselect, so a window's records and done pulse are all out before the next window starts, and it checks at the end that the queue has drained.

// File: rtl/mw_mon_pkg.sv
package mw_mon_pkg;
  // raw line index after synchronizer
  localparam int LN_CS = 0;
  localparam int LN_SK = 1;
  localparam int LN_SI = 2;
  localparam int LN_SO = 3;
  localparam int N_LINES = 4;
  // edge detector lanes
  localparam int ED_CS = 0;
  localparam int ED_SK = 1;
  localparam int ED_SO = 2;
  localparam int N_EDGE = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } mw_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_edge.sv
module mw_edge #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/mw_stat_buf.sv
module mw_stat_buf #(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic push_i,
  input  logic push_val_i,
  input  logic pop_i,
  output logic head_o,
  output logic empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full) begin
        mem_q[wr_q] <= push_val_i;
        wr_q        <= nxt(wr_q);
        cnt_q       <= cnt_q + CW'(1);
      end else if (pop_i && !empty_o) begin
        rd_q  <= nxt(rd_q);
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_BUF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/mw_core.sv
module mw_core
  import mw_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             sk_lvl_i,
  input  logic             sk_rise_i,
  input  logic             sk_fall_i,
  input  logic             si_lvl_i,
  input  logic             so_lvl_i,
  input  logic             so_chg_i,
  input  logic             buf_empty_i,
  input  logic             buf_head_i,
  output logic             buf_clr_o,
  output logic             buf_push_o,
  output logic             buf_pop_o,
  output logic             bit_valid_o,
  output logic             bit_si_o,
  output logic             bit_so_o,
  output logic             bit_is_start_o,
  output logic             status_valid_o,
  output logic             status_ready_o,
  output logic             warn_clk_high_o,
  output logic             txn_done_o,
  output logic [CNT_W-1:0] txn_bits_o
);
  mw_state_e        state_q;
  logic             mask_q;      // clock seen high at select
  logic             classed_q;
  logic             is_xfer_q;
  logic             have_bit_q;
  logic             cur_si_q, cur_so_q, cur_start_q;
  logic             so_last_q;   // data-out level for final status
  logic [CNT_W-1:0] cnt_q;

  assign buf_clr_o  = (state_q == ST_IDLE) && cs_rise_i;
  assign buf_push_o = (state_q == ST_WIN) && !cs_fall_i && so_chg_i && !is_xfer_q;
  assign buf_pop_o  = (state_q == ST_DRAIN) && !buf_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      mask_q          <= 1'b0;
      classed_q       <= 1'b0;
      is_xfer_q       <= 1'b0;
      have_bit_q      <= 1'b0;
      cur_si_q        <= 1'b0;
      cur_so_q        <= 1'b0;
      cur_start_q     <= 1'b0;
      so_last_q       <= 1'b0;
      cnt_q           <= '0;
      bit_valid_o     <= 1'b0;
      bit_si_o        <= 1'b0;
      bit_so_o        <= 1'b0;
      bit_is_start_o  <= 1'b0;
      status_valid_o  <= 1'b0;
      status_ready_o  <= 1'b0;
      warn_clk_high_o <= 1'b0;
      txn_done_o      <= 1'b0;
      txn_bits_o      <= '0;
    end else begin
      bit_valid_o     <= 1'b0;
      status_valid_o  <= 1'b0;
      warn_clk_high_o <= 1'b0;
      txn_done_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cs_rise_i) begin
            state_q         <= ST_WIN;
            warn_clk_high_o <= sk_lvl_i;
            mask_q          <= sk_lvl_i;
            classed_q       <= 1'b0;
            is_xfer_q       <= 1'b0;
            have_bit_q      <= 1'b0;
            cur_si_q        <= 1'b0;
            cur_so_q        <= 1'b0;
            cur_start_q     <= 1'b0;
            so_last_q       <= so_lvl_i;
            cnt_q           <= '0;
          end
        end
        ST_WIN: begin
          if (cs_fall_i) begin
            // close the open bit only with the clock low
            if (is_xfer_q && have_bit_q && !sk_lvl_i) begin
              bit_valid_o    <= 1'b1;
              bit_si_o       <= cur_si_q;
              bit_so_o       <= cur_so_q;
              bit_is_start_o <= cur_start_q;
              cnt_q          <= cnt_q + CNT_W'(1);
            end
            state_q <= is_xfer_q ? ST_DONE : ST_DRAIN;
          end else begin
            if (so_chg_i) so_last_q <= so_lvl_i;
            if (sk_fall_i) begin
              if (mask_q) mask_q   <= 1'b0;
              else        cur_so_q <= so_lvl_i;
            end
            if (sk_rise_i) begin
              if (!classed_q) begin
                classed_q <= 1'b1;
                if (si_lvl_i) begin
                  is_xfer_q   <= 1'b1;
                  have_bit_q  <= 1'b1;
                  cur_si_q    <= 1'b1;
                  cur_start_q <= 1'b1;
                end
              end else if (is_xfer_q) begin
                bit_valid_o    <= 1'b1;
                bit_si_o       <= cur_si_q;
                bit_so_o       <= cur_so_q;
                bit_is_start_o <= cur_start_q;
                cnt_q          <= cnt_q + CNT_W'(1);
                cur_si_q       <= si_lvl_i;
                cur_start_q    <= 1'b0;
              end
            end
          end
        end
        ST_DRAIN: begin
          status_valid_o <= 1'b1;
          if (!buf_empty_i) begin
            status_ready_o <= buf_head_i;
          end else begin
            status_ready_o <= so_last_q;
            state_q        <= ST_DONE;
          end
        end
        ST_DONE: begin
          txn_done_o <= 1'b1;
          txn_bits_o <= cnt_q;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_IS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && bit_is_start_o) |-> bit_si_o); // R5
  AST_BIT_FROM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(state_q == ST_WIN)); // R6
  AST_ONE_RECORD_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && status_valid_o)); // R8
  AST_DONE_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_done_o |-> (!bit_valid_o && !status_valid_o)); // R2
  AST_WARN_AT_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_clk_high_o |-> $past(cs_rise_i && sk_lvl_i)); // R3
  AST_NO_STATUS_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> !is_xfer_q); // R9
endmodule

// File: rtl/mw_monitor.sv
module mw_monitor
  import mw_mon_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STAT_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mw_cs_i,
  input  logic             mw_sk_i,
  input  logic             mw_si_i,
  input  logic             mw_so_i,
  output logic             bit_valid_o,
  output logic             bit_si_o,
  output logic             bit_so_o,
  output logic             bit_is_start_o,
  output logic             status_valid_o,
  output logic             status_ready_o,
  output logic             warn_clk_high_o,
  output logic             txn_done_o,
  output logic [CNT_W-1:0] txn_bits_o
);
  logic [N_LINES-1:0] raw, syn;
  logic [N_EDGE-1:0]  ed_in, rise, fall;
  logic               buf_clr, buf_push, buf_pop, buf_head, buf_empty;

  always_comb begin
    raw        = '0;
    raw[LN_CS] = mw_cs_i;
    raw[LN_SK] = mw_sk_i;
    raw[LN_SI] = mw_si_i;
    raw[LN_SO] = mw_so_i;
    ed_in        = '0;
    ed_in[ED_CS] = syn[LN_CS];
    ed_in[ED_SK] = syn[LN_SK];
    ed_in[ED_SO] = syn[LN_SO];
  end

  mw_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  mw_edge #(.W(N_EDGE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ed_in),
    .rise_o(rise),
    .fall_o(fall)
  );

  mw_stat_buf #(.DEPTH(STAT_DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .push_i    (buf_push),
    .push_val_i(syn[LN_SO]),
    .pop_i     (buf_pop),
    .head_o    (buf_head),
    .empty_o   (buf_empty)
  );

  mw_core #(.CNT_W(CNT_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cs_rise_i      (rise[ED_CS]),
    .cs_fall_i      (fall[ED_CS]),
    .sk_lvl_i       (syn[LN_SK]),
    .sk_rise_i      (rise[ED_SK]),
    .sk_fall_i      (fall[ED_SK]),
    .si_lvl_i       (syn[LN_SI]),
    .so_lvl_i       (syn[LN_SO]),
    .so_chg_i       (rise[ED_SO] | fall[ED_SO]),
    .buf_empty_i    (buf_empty),
    .buf_head_i     (buf_head),
    .buf_clr_o      (buf_clr),
    .buf_push_o     (buf_push),
    .buf_pop_o      (buf_pop),
    .bit_valid_o    (bit_valid_o),
    .bit_si_o       (bit_si_o),
    .bit_so_o       (bit_so_o),
    .bit_is_start_o (bit_is_start_o),
    .status_valid_o (status_valid_o),
    .status_ready_o (status_ready_o),
    .warn_clk_high_o(warn_clk_high_o),
    .txn_done_o     (txn_done_o),
    .txn_bits_o     (txn_bits_o)
  );
endmodule

// File: tb/mw_monitor_tb.sv
`timescale 1ns/1ps
module mw_monitor_tb;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [1:0]  kind;  // 0 bit, 1 status, 2 done
    logic        a;
    logic        b;
    logic        c;
    logic [15:0] n;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
  logic bit_valid, bit_si, bit_so, bit_start;
  logic st_valid, st_ready, warn, done;
  logic [CNT_W-1:0] nbits;

  int checks = 0;
  int fails = 0;
  int exp_warn = 0;
  int seen_warn = 0;
  bit finished = 1'b0;
  item_t exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  mw_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mw_cs_i(cs), .mw_sk_i(sk), .mw_si_i(si), .mw_so_i(so),
    .bit_valid_o(bit_valid), .bit_si_o(bit_si), .bit_so_o(bit_so),
    .bit_is_start_o(bit_start),
    .status_valid_o(st_valid), .status_ready_o(st_ready),
    .warn_clk_high_o(warn), .txn_done_o(done), .txn_bits_o(nbits)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input item_t it, input string tag);
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic take(input item_t got);
    item_t e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R9 unexpected record act=%h exp=none", got);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (got !== e) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", t, got, e);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (warn) seen_warn++;
      if (bit_valid) take('{kind: 2'd0, a: bit_si, b: bit_so, c: bit_start, n: 16'd0});
      if (st_valid)  take('{kind: 2'd1, a: st_ready, b: 1'b0, c: 1'b0, n: 16'd0});
      if (done)      take('{kind: 2'd2, a: 1'b0, b: 1'b0, c: 1'b0, n: 16'(nbits)});
    end
  end

  task automatic run_xfer(input logic [31:0] siv, input logic [31:0] sov, input int n,
                          input bit clk_hi, input bit end_hi);
    int nrec = end_hi ? n - 1 : n;
    for (int i = 0; i < nrec; i++) begin
      string t;
      if (i == 0) t = clk_hi ? "R3" : "R5";
      else if (i == n - 1) t = "R6";
      else t = "R4";
      expect_item('{kind: 2'd0, a: siv[i], b: sov[i], c: (i == 0), n: 16'd0}, t);
    end
    expect_item('{kind: 2'd2, a: 1'b0, b: 1'b0, c: 1'b0, n: 16'(nrec)}, end_hi ? "R6" : "R2");
    if (clk_hi) exp_warn++;
    so = 1'b0; si = 1'b0; sk = clk_hi;
    cyc(6);
    cs = 1'b1;
    cyc(6);
    if (clk_hi) begin
      so = 1'b1;  // ignored fall must not capture this
      sk = 1'b0;
      cyc(6);
      so = 1'b0;
      cyc(4);
    end
    for (int i = 0; i < n; i++) begin
      si = siv[i];
      cyc(4);
      sk = 1'b1;
      cyc(2);
      so = sov[i];
      cyc(4);
      if (!(end_hi && i == n - 1)) begin
        sk = 1'b0;
        cyc(4);
      end
    end
    cs = 1'b0;
    cyc(4);
    sk = 1'b0; si = 1'b0; so = 1'b0;
    cyc(30);
  endtask

  task automatic run_poll(input logic so0, input logic [15:0] lv, input int nchg,
                          input int nclk);
    logic cur = so0;
    for (int j = 0; j < nchg; j++) begin
      if (lv[j] != cur)
        expect_item('{kind: 2'd1, a: lv[j], b: 1'b0, c: 1'b0, n: 16'd0}, "R8");
      cur = lv[j];
    end
    expect_item('{kind: 2'd1, a: cur, b: 1'b0, c: 1'b0, n: 16'd0}, "R8");
    expect_item('{kind: 2'd2, a: 1'b0, b: 1'b0, c: 1'b0, n: 16'd0}, nclk > 0 ? "R7" : "R2");
    so = so0; si = 1'b0; sk = 1'b0;
    cyc(6);
    cs = 1'b1;
    cyc(6);
    for (int k = 0; k < nclk; k++) begin
      si = (k > 0);
      cyc(4);
      sk = 1'b1;
      cyc(4);
      sk = 1'b0;
      cyc(4);
    end
    for (int j = 0; j < nchg; j++) begin
      so = lv[j];
      cyc(10);
    end
    cs = 1'b0;
    cyc(4);
    si = 1'b0; so = 1'b0;
    cyc(40);
  endtask

  initial begin
    cyc(5);
    checks++;
    if (bit_valid || st_valid || warn || done) begin
      fails++;
      $display("FAIL R1 pulses in reset act=%b%b%b%b exp=0000", bit_valid, st_valid, warn, done);
    end
    rst_n = 1'b1;
    cyc(20);
    checks++;
    if (exp_q.size() != 0 || seen_warn != 0) begin
      fails++;
      $display("FAIL R1 idle activity act=%0d exp=0", seen_warn);
    end
    run_xfer(32'h0000_00A7, 32'h0000_005A, 8, 1'b0, 1'b0);
    run_xfer(32'h0000_0005, 32'h0000_0002, 3, 1'b0, 1'b0);
    run_xfer(32'h0000_0A35, 32'h0000_03C9, 12, 1'b1, 1'b0);
    run_xfer(32'h0000_0013, 32'h0000_001F, 5, 1'b0, 1'b1);
    run_poll(1'b0, 16'h0001, 1, 0);
    run_poll(1'b1, 16'h0005, 4, 2);
    run_poll(1'b0, 16'h0000, 0, 0);
    run_poll(1'b1, 16'h0000, 1, 1);
    run_xfer(32'h0000_0001, 32'h0000_0001, 1, 1'b0, 1'b0);
    run_xfer(32'h0000_FFFF, 32'h0000_0F0F, 16, 1'b0, 1'b0);
    run_xfer(32'h8000_0001, 32'hFFFF_0000, 32, 1'b1, 1'b0);
    cyc(50);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 records missing act=%0d exp=0", exp_q.size());
    end
    checks++;
    if (seen_warn != exp_warn) begin
      fails++;
      $display("FAIL R3 warn count act=%0d exp=%0d", seen_warn, exp_warn);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule